// File: doc/BRIEF.md
# Blind Adaptive QAM Equalizer

This block removes echoes from a complex-baseband QAM signal. It takes one complex symbol-rate sample per accepted handshake. For each sample it produces one filtered complex symbol and a 16-QAM hard decision. The filter has 32 complex taps.

Two configuration inputs control the structure:
- `cfg_dfe` chooses between a pure feed-forward (transversal) filter and a decision-feedback filter. In decision-feedback mode, the taps after the reference tap are fed with past decisions.
- `cfg_ref` sets the reference tap. This trades coverage of pre-cursor echoes against coverage of post-cursor echoes.

The block needs no training sequence. It starts in blind mode, where coefficients adapt with a constant-modulus error. Once the distance between the output and its decision has stayed small for `cfg_lock_len` consecutive symbols, it switches to decision-directed LMS.

Control is a four-state machine:
- **IDLE**: waits for a sample. The edge on which `in_valid && in_ready` holds moves the machine to MAC.
- **MAC**: one complex multiplier accumulates one tap per cycle. After tap 31 the machine moves to SLICE.
- **SLICE**: the output, decision, error and lock counter are registered. The machine always moves to UPDATE.
- **UPDATE**: one coefficient is adapted per cycle. After tap 31 the machine returns to IDLE.

A change of `cfg_dfe` or `cfg_ref` sends any state back to IDLE and restarts acquisition.

Top module: `adaptive_qam_equalizer`

## Requirements
- R1: After reset, `in_ready`=1, `out_valid`=0 and `dd_mode`=0. Every coefficient is zero except tap `cfg_ref`, which is 1.0 (real 256, since 1.0 = 2^8). Samples and coefficients are signed 12-bit with 8 fraction bits.
- R2: A sample is taken on a rising edge with `in_valid && in_ready`. `in_ready` then stays low for exactly 2*NTAPS+1 cycles (65).
- R3: `out_valid` is a one-cycle pulse. It is high in the cycle after the (NTAPS+1)th rising edge that follows the accepting edge.
- R4: The output is y = sat12((Σ c_k·u_k) >>> 8), using complex products. In transversal mode, u_k is the sample taken k symbols before the newest one (u_0 is the newest sample).
- R5: When `cfg_dfe`=1, each tap k > `cfg_ref` uses u_k = the decision made (k−`cfg_ref`) symbols earlier. The other taps use samples as in R4.
- R6: Each decision component is one of four levels: 192 if y≥128; 64 if 0≤y<128; −64 if −128≤y<0; −192 if y<−128.
- R7: In blind mode the error is e = sat12((y·(m−211)) >>> 8), where m = (yr²+yi²) >>> 8.
- R8: In decision-directed mode the error is e = sat12(y−d). Every tap is then updated as c_k ← sat12(c_k − ((e·conj(u_k)) >>> (8+`cfg_mu`))).
- R9: A symbol is "low" when |yr−dr|+|yi−di| < 32. When a run of consecutive low symbols reaches `cfg_lock_len`, `dd_mode` goes to 1 with that symbol's output. That symbol itself is still adapted with the blind error. `cfg_lock_len`=0 keeps the block blind. `dd_mode` stays at 1 until a restart.
- R10: A change of `cfg_dfe` or `cfg_ref` does all of the following:
  - restores the coefficients of R1 for the new reference tap;
  - clears the sample and decision histories;
  - returns the block to blind mode with the low-symbol run count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dfe | input | 1 | 1 = decision-feedback structure, 0 = transversal |
| cfg_ref | input | 5 | Reference tap index |
| cfg_mu | input | 4 | Step-size right shift, added to the 8 fraction bits |
| cfg_lock_len | input | 16 | Run of low-error symbols needed to leave blind mode (0 = never) |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_re | input | 12 | Input sample, real part |
| in_im | input | 12 | Input sample, imaginary part |
| out_valid | output | 1 | One-cycle pulse, output fields are new |
| out_re | output | 12 | Equalized symbol, real part |
| out_im | output | 12 | Equalized symbol, imaginary part |
| dec_re | output | 12 | Hard decision, real part |
| dec_im | output | 12 | Hard decision, imaginary part |
| dd_mode | output | 1 | 0 = blind adaptation, 1 = decision-directed |

## Verification
The bench drives the following patterns:
- **Clean 16-QAM points with small noise through the identity filter.** This separates a correct blind-to-directed switch from an early or late one, because every symbol counts as low.
- **A single impulse followed by zeros after the reference tap is moved.** This shows whether the restart rebuilt the reference tap at the new index and cleared the history.
- **Random constellation symbols in decision-feedback mode.** These tell apart feedback taps fed from the decision history and taps fed from the sample history.
- **Full-range random samples with large steps.** These drive the output, error and coefficient saturation paths.
- **Random reference, structure and step settings.** These cover the remaining corners.

// File: rtl/eq_pkg.sv
package eq_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_SLICE, ST_UPDATE} eq_state_t;

    typedef logic signed [47:0] wide_t;

    // clamp a wide value into the signed range of a given width
    function automatic wide_t clampw(input wide_t v, input int bits);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (bits - 1)) - wide_t'(1);
        lo = -hi - wide_t'(1);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic wide_t absw(input wide_t v);
        return (v < 0) ? -v : v;
    endfunction
endpackage

// File: rtl/eq_ctrl.sv
module eq_ctrl
    import eq_pkg::*;
#(
    parameter  int NTAPS = 32,
    localparam int TAPW  = $clog2(NTAPS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            in_valid,
    output logic            in_ready,
    output logic            accept,
    output logic            mac_en,
    output logic            slice_en,
    output logic            upd_en,
    output logic [TAPW-1:0] idx
);
    localparam logic [TAPW-1:0] LAST = TAPW'(NTAPS - 1);

    eq_state_t       state_q, state_d;
    logic [TAPW-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (accept) state_d = ST_MAC;
            end
            ST_MAC: begin
                if (idx_q == LAST) begin
                    state_d = ST_SLICE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_SLICE: begin
                state_d = ST_UPDATE;
                idx_d   = '0;
            end
            ST_UPDATE: begin
                if (idx_q == LAST) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = (state_q == ST_IDLE) && !restart;
        accept   = in_ready && in_valid;
        mac_en   = (state_q == ST_MAC);
        slice_en = (state_q == ST_SLICE);
        upd_en   = (state_q == ST_UPDATE);
        idx      = idx_q;
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    assert_slice_after_last_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && idx == LAST && !restart) |=> slice_en);
endmodule

// File: rtl/eq_mac.sv
module eq_mac
    import eq_pkg::*;
#(
    parameter int DW   = 12,
    parameter int FRAC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 en,
    input  logic signed [DW-1:0] cr,
    input  logic signed [DW-1:0] ci,
    input  logic signed [DW-1:0] ur,
    input  logic signed [DW-1:0] ui,
    output logic signed [DW-1:0] yr,
    output logic signed [DW-1:0] yi
);
    wide_t acc_re, acc_im;
    wide_t p_re, p_im;

    always_comb begin
        p_re = wide_t'(cr) * wide_t'(ur) - wide_t'(ci) * wide_t'(ui);
        p_im = wide_t'(cr) * wide_t'(ui) + wide_t'(ci) * wide_t'(ur);
        yr   = DW'(clampw(acc_re >>> FRAC, DW));
        yi   = DW'(clampw(acc_im >>> FRAC, DW));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (en) begin
            acc_re <= acc_re + p_re;
            acc_im <= acc_im + p_im;
        end
    end
endmodule

// File: rtl/eq_slicer.sv
module eq_slicer
    import eq_pkg::*;
#(
    parameter int DW       = 12,
    parameter int FRAC     = 8,
    parameter int UNIT     = 64,
    parameter int CMA_R2   = 211,
    parameter int LOCK_THR = 32
) (
    input  logic                 dd_mode,
    input  logic signed [DW-1:0] yr,
    input  logic signed [DW-1:0] yi,
    output logic signed [DW-1:0] dr,
    output logic signed [DW-1:0] di,
    output logic signed [DW-1:0] er,
    output logic signed [DW-1:0] ei,
    output logic                 low
);
    function automatic logic signed [DW-1:0] level(input logic signed [DW-1:0] y);
        if (y >= 2 * UNIT) return DW'(3 * UNIT);
        if (y >= 0)        return DW'(UNIT);
        if (y >= -2 * UNIT) return DW'(-UNIT);
        return DW'(-3 * UNIT);
    endfunction

    wide_t wr, wi, mod2, tdev;

    always_comb begin
        dr   = level(yr);
        di   = level(yi);
        wr   = wide_t'(yr) - wide_t'(dr);
        wi   = wide_t'(yi) - wide_t'(di);
        mod2 = (wide_t'(yr) * wide_t'(yr) + wide_t'(yi) * wide_t'(yi)) >>> FRAC;
        tdev = mod2 - wide_t'(CMA_R2);
        low  = (absw(wr) + absw(wi)) < wide_t'(LOCK_THR);
        if (dd_mode) begin
            er = DW'(clampw(wr, DW));
            ei = DW'(clampw(wi, DW));
        end else begin
            er = DW'(clampw((wide_t'(yr) * tdev) >>> FRAC, DW));
            ei = DW'(clampw((wide_t'(yi) * tdev) >>> FRAC, DW));
        end
    end
endmodule

// File: rtl/adaptive_qam_equalizer.sv
module adaptive_qam_equalizer
    import eq_pkg::*;
#(
    parameter  int NTAPS    = 32,
    parameter  int DW       = 12,
    parameter  int FRAC     = 8,
    parameter  int UNIT     = 64,
    parameter  int CMA_R2   = 211,
    parameter  int LOCK_THR = 32,
    parameter  int MUW      = 4,
    parameter  int LCW      = 16,
    localparam int TAPW     = $clog2(NTAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_dfe,
    input  logic [TAPW-1:0]      cfg_ref,
    input  logic [MUW-1:0]       cfg_mu,
    input  logic [LCW-1:0]       cfg_lock_len,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im,
    output logic signed [DW-1:0] dec_re,
    output logic signed [DW-1:0] dec_im,
    output logic                 dd_mode
);
    localparam logic signed [DW-1:0] ONE = DW'(1 << FRAC);

    logic signed [DW-1:0] coef_re [NTAPS];
    logic signed [DW-1:0] coef_im [NTAPS];
    logic signed [DW-1:0] sl_re   [NTAPS];
    logic signed [DW-1:0] sl_im   [NTAPS];
    logic signed [DW-1:0] dl_re   [NTAPS];
    logic signed [DW-1:0] dl_im   [NTAPS];
    logic signed [DW-1:0] dlast_re, dlast_im, err_re, err_im;
    logic [LCW-1:0]       lock_cnt, lock_next;
    logic                 dfe_q;
    logic [TAPW-1:0]      ref_q;
    logic                 restart, accept, mac_en, slice_en, upd_en;
    logic [TAPW-1:0]      idx;
    logic signed [DW-1:0] u_re, u_im, y_re, y_im, d_re, d_im, e_re, e_im;
    logic signed [DW-1:0] c_new_re, c_new_im;
    logic                 low;
    wide_t                g_re, g_im;

    // configuration shadow; any change restarts acquisition
    always_ff @(posedge clk) begin
        dfe_q <= cfg_dfe;
        ref_q <= cfg_ref;
    end
    assign restart = (cfg_dfe != dfe_q) || (cfg_ref != ref_q);

    eq_ctrl #(.NTAPS(NTAPS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
        .in_ready(in_ready), .accept(accept), .mac_en(mac_en),
        .slice_en(slice_en), .upd_en(upd_en), .idx(idx)
    );

    // regressor: decision history feeds taps past the reference in feedback mode
    always_comb begin
        if (dfe_q && idx > ref_q) begin
            u_re = dl_re[TAPW'(idx - ref_q - 1'b1)];
            u_im = dl_im[TAPW'(idx - ref_q - 1'b1)];
        end else begin
            u_re = sl_re[idx];
            u_im = sl_im[idx];
        end
    end

    eq_mac #(.DW(DW), .FRAC(FRAC)) u_mac (
        .clk(clk), .rst_n(rst_n), .clear(accept), .en(mac_en),
        .cr(coef_re[idx]), .ci(coef_im[idx]), .ur(u_re), .ui(u_im),
        .yr(y_re), .yi(y_im)
    );

    eq_slicer #(.DW(DW), .FRAC(FRAC), .UNIT(UNIT), .CMA_R2(CMA_R2),
                .LOCK_THR(LOCK_THR)) u_slicer (
        .dd_mode(dd_mode), .yr(y_re), .yi(y_im), .dr(d_re), .di(d_im),
        .er(e_re), .ei(e_im), .low(low)
    );

    // coefficient gradient: error times conjugate regressor
    always_comb begin
        g_re = (wide_t'(err_re) * wide_t'(u_re) + wide_t'(err_im) * wide_t'(u_im))
               >>> (FRAC + int'(cfg_mu));
        g_im = (wide_t'(err_im) * wide_t'(u_re) - wide_t'(err_re) * wide_t'(u_im))
               >>> (FRAC + int'(cfg_mu));
        c_new_re  = DW'(clampw(wide_t'(coef_re[idx]) - g_re, DW));
        c_new_im  = DW'(clampw(wide_t'(coef_im[idx]) - g_im, DW));
        lock_next = lock_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            for (int k = 0; k < NTAPS; k++) begin
                coef_re[k] <= (TAPW'(k) == cfg_ref) ? ONE : '0;
                coef_im[k] <= '0;
                sl_re[k]   <= '0;
                sl_im[k]   <= '0;
                dl_re[k]   <= '0;
                dl_im[k]   <= '0;
            end
            dlast_re  <= '0;
            dlast_im  <= '0;
            err_re    <= '0;
            err_im    <= '0;
            lock_cnt  <= '0;
            dd_mode   <= 1'b0;
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
            dec_re    <= '0;
            dec_im    <= '0;
        end else begin
            out_valid <= 1'b0;
            if (accept) begin
                sl_re[0] <= in_re;
                sl_im[0] <= in_im;
                dl_re[0] <= dlast_re;
                dl_im[0] <= dlast_im;
                for (int k = 1; k < NTAPS; k++) begin
                    sl_re[k] <= sl_re[k-1];
                    sl_im[k] <= sl_im[k-1];
                    dl_re[k] <= dl_re[k-1];
                    dl_im[k] <= dl_im[k-1];
                end
            end
            if (slice_en) begin
                out_valid <= 1'b1;
                out_re    <= y_re;
                out_im    <= y_im;
                dec_re    <= d_re;
                dec_im    <= d_im;
                dlast_re  <= d_re;
                dlast_im  <= d_im;
                err_re    <= e_re;
                err_im    <= e_im;
                if (!dd_mode) begin
                    if (low) begin
                        lock_cnt <= lock_next;
                        if (cfg_lock_len != '0 && lock_next == cfg_lock_len)
                            dd_mode <= 1'b1;
                    end else begin
                        lock_cnt <= '0;
                    end
                end
            end
            if (upd_en) begin
                coef_re[idx] <= c_new_re;
                coef_im[idx] <= c_new_im;
            end
        end
    end

    // cycles since the last accepted sample, for the latency check
    logic [15:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)              age <= 16'hFFFF;
        else if (accept)         age <= '0;
        else if (age != 16'hFFFF) age <= age + 1'b1;
    end

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> age == 16'(NTAPS + 1));

    assert_level_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((dec_re == DW'(UNIT) || dec_re == DW'(-UNIT) ||
                        dec_re == DW'(3*UNIT) || dec_re == DW'(-3*UNIT)) &&
                       (dec_im == DW'(UNIT) || dec_im == DW'(-UNIT) ||
                        dec_im == DW'(3*UNIT) || dec_im == DW'(-3*UNIT))));

    assert_mode_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dd_mode && !restart) |=> dd_mode);

    assert_restart_blind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!dd_mode && in_ready));
endmodule

// File: tb/adaptive_qam_equalizer_test.sv
`timescale 1ns/1ps
module adaptive_qam_equalizer_test;
    localparam int NT = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n, cfg_dfe, in_valid, in_ready, out_valid, dd_mode;
    logic [4:0]        cfg_ref;
    logic [3:0]        cfg_mu;
    logic [15:0]       cfg_lock_len;
    logic signed [11:0] in_re, in_im, out_re, out_im, dec_re, dec_im;

    adaptive_qam_equalizer uut (
        .clk(clk), .rst_n(rst_n), .cfg_dfe(cfg_dfe), .cfg_ref(cfg_ref),
        .cfg_mu(cfg_mu), .cfg_lock_len(cfg_lock_len), .in_valid(in_valid),
        .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .dec_re(dec_re), .dec_im(dec_im), .dd_mode(dd_mode)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    longint mc_re[NT], mc_im[NT], ms_re[NT], ms_im[NT], md_re[NT], md_im[NT];
    longint mdl_re, mdl_im;
    int     mmode, mcnt;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat12(input longint v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic longint lvl(input longint y);
        if (y >= 128) return 192;
        if (y >= 0) return 64;
        if (y >= -128) return -64;
        return -192;
    endfunction

    function automatic longint labs(input longint v);
        return v < 0 ? -v : v;
    endfunction

    task automatic model_reset(input int refp);
        for (int k = 0; k < NT; k++) begin
            mc_re[k] = (k == refp) ? 256 : 0; mc_im[k] = 0;
            ms_re[k] = 0; ms_im[k] = 0; md_re[k] = 0; md_im[k] = 0;
        end
        mdl_re = 0; mdl_im = 0; mmode = 0; mcnt = 0;
    endtask

    task automatic model_step(input longint xr, input longint xi,
                              output longint yr, output longint yi,
                              output longint dr, output longint di);
        longint ur[NT], ui[NT];
        longint ar, ai, er, ei, m, t, gr, gi;
        int     refp;
        refp = int'(cfg_ref);
        for (int k = NT - 1; k > 0; k--) begin
            ms_re[k] = ms_re[k-1]; ms_im[k] = ms_im[k-1];
            md_re[k] = md_re[k-1]; md_im[k] = md_im[k-1];
        end
        ms_re[0] = xr; ms_im[0] = xi; md_re[0] = mdl_re; md_im[0] = mdl_im;
        ar = 0; ai = 0;
        for (int k = 0; k < NT; k++) begin
            if (cfg_dfe && k > refp) begin ur[k] = md_re[k-refp-1]; ui[k] = md_im[k-refp-1]; end
            else begin ur[k] = ms_re[k]; ui[k] = ms_im[k]; end
            ar += mc_re[k] * ur[k] - mc_im[k] * ui[k];
            ai += mc_re[k] * ui[k] + mc_im[k] * ur[k];
        end
        yr = sat12(ar >>> 8); yi = sat12(ai >>> 8);
        dr = lvl(yr); di = lvl(yi);
        if (mmode != 0) begin
            er = sat12(yr - dr); ei = sat12(yi - di);
        end else begin
            m = (yr * yr + yi * yi) >>> 8;
            t = m - 211;
            er = sat12((yr * t) >>> 8); ei = sat12((yi * t) >>> 8);
        end
        if (mmode == 0) begin
            if (labs(yr - dr) + labs(yi - di) < 32) begin
                mcnt++;
                if (cfg_lock_len != 0 && mcnt == int'(cfg_lock_len)) mmode = 1;
            end else mcnt = 0;
        end
        mdl_re = dr; mdl_im = di;
        for (int k = 0; k < NT; k++) begin
            gr = (er * ur[k] + ei * ui[k]) >>> (8 + int'(cfg_mu));
            gi = (ei * ur[k] - er * ui[k]) >>> (8 + int'(cfg_mu));
            mc_re[k] = sat12(mc_re[k] - gr);
            mc_im[k] = sat12(mc_im[k] - gi);
        end
    endtask

    // send one sample, check timing, outputs and mode
    task automatic send(input longint xr, input longint xi, input string tag);
        longint yr, yi, dr, di;
        int k, lowc, got;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_re = 12'(xr); in_im = 12'(xi);
        @(negedge clk);
        in_valid = 1'b0;
        model_step(xr, xi, yr, yi, dr, di);
        k = 1; lowc = 0; got = 0;
        forever begin
            if (!in_ready) lowc++;
            if (out_valid) begin
                got++;
                chk("R3", "latency", k, NT + 2);
                chk(tag, "out_re", out_re, yr);
                chk(tag, "out_im", out_im, yi);
                chk("R6", "dec_re", dec_re, dr);
                chk("R6", "dec_im", dec_im, di);
                chk("R9", "dd_mode", dd_mode, mmode);
            end
            if (in_ready) break;
            @(negedge clk);
            k++;
        end
        chk("R3", "valid pulses", got, 1);
        chk("R2", "busy cycles", lowc, 2 * NT + 1);
    endtask

    function automatic longint qam();
        case ($urandom_range(3))
            0: return -192;
            1: return -64;
            2: return 64;
            default: return 192;
        endcase
    endfunction

    function automatic longint noise(input int a);
        return longint'($urandom_range(2 * a)) - a;
    endfunction

    task automatic reconfig(input logic dfe, input logic [4:0] r, input logic [3:0] mu,
                            input logic [15:0] ll);
        @(negedge clk);
        cfg_dfe = dfe; cfg_ref = r; cfg_mu = mu; cfg_lock_len = ll;
        @(negedge clk);
        @(negedge clk);
        model_reset(int'(r));
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        rst_n = 1'b0; in_valid = 1'b0; in_re = '0; in_im = '0;
        cfg_dfe = 1'b0; cfg_ref = 5'd0; cfg_mu = 4'd6; cfg_lock_len = 16'd4;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "in_ready", in_ready, 1);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "dd_mode", dd_mode, 0);
        model_reset(0);

        // identity reference tap: first output equals input
        send(64, -192, "R1");
        // clean constellation with small noise: blind then directed
        for (int i = 0; i < 6; i++) send(qam() + noise(8), qam() + noise(8), "R7");
        chk("R9", "switched to directed", dd_mode, 1);
        for (int i = 0; i < 14; i++) send(qam() + noise(8), qam() + noise(8), "R8");

        // move the reference tap: restart, impulse appears after ref symbols
        reconfig(1'b0, 5'd5, 4'd6, 16'd0);
        chk("R10", "dd_mode after restart", dd_mode, 0);
        chk("R10", "in_ready after restart", in_ready, 1);
        send(192, 64, "R10");
        for (int i = 0; i < 4; i++) send(0, 0, "R10");
        @(negedge clk);
        send(0, 0, "R10");
        chk("R10", "impulse at new ref re", out_re, 192);
        chk("R10", "impulse at new ref im", out_im, 64);
        // lock length zero: stays blind
        for (int i = 0; i < 25; i++) send(qam(), qam(), "R4");
        chk("R9", "no switch with zero length", dd_mode, 0);

        // decision feedback structure
        reconfig(1'b1, 5'd3, 4'd5, 16'd3);
        for (int i = 0; i < 40; i++) send(qam() + noise(12), qam() + noise(12), "R5");

        // full-range inputs, large steps: saturation
        reconfig(1'b0, 5'd0, 4'd2, 16'd2);
        for (int i = 0; i < 30; i++)
            send(longint'($urandom_range(4095)) - 2048, longint'($urandom_range(4095)) - 2048, "R4");
        send(2047, -2048, "R4");

        // random settings
        for (int j = 0; j < 3; j++) begin
            logic [4:0] nr;
            nr = 5'((int'(cfg_ref) + 1 + int'($urandom_range(30))) % NT);
            reconfig(1'($urandom_range(1)), nr, 4'(3 + $urandom_range(5)),
                     16'(1 + $urandom_range(5)));
            for (int i = 0; i < 20; i++)
                send(qam() + noise(20), qam() + noise(20), cfg_dfe ? "R5" : "R8");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule